// File: doc/BRIEF.md
# SPI Memory Command Controller

This block is the serial slave front end of a 4096-byte memory. It samples chip select, serial clock and serial data into a faster system clock and finds their edges there. It decodes single-byte commands and gathers a 16-bit address. It streams array bytes or the status byte back on a tri-stated serial output. Write data goes into a one-page buffer of 32 bytes. When chip select rises at a legal point, a timed write cycle starts.

The array itself sits outside the block, behind a combinational read port and a byte-wide write port. A neighbouring protection block supplies three things: a per-address write permission, a permission to change the status byte, and the three stored status bits it owns (a write-protect enable and two lock-range bits). The system clock must run at least eight times faster than the serial clock.

Top module: `spi_mem_ctrl`

## Requirements
- R1: Input bits are taken on rising serial-clock edges and output bits change on falling edges, MSB first. Reads return correct data both with the clock idling low and with it idling high.
- R2: After reset no command is accepted until chip select has gone from high to low. If chip select is held low through reset, clocked commands get no response and the output is not driven.
- R3: `miso_oe` is low whenever chip select is high, and low outside the data phase of a read or status read.
- R4: The status byte has these bits: bit 7 is the protection enable from the neighbour, bit 6 is the flag, bits 5:4 always read 1, bits 3:2 are the two lock bits, bit 1 is WEL and bit 0 is WIP. After reset, with the neighbour bits at zero, it reads 0x30.
- R5: Opcode 0x06 sets WEL only if chip select rises right after its eighth bit. Any further clocking in the same selection leaves WEL unchanged.
- R6: Opcode 0x04 clears WEL and the flag. Opcode 0x00 sets the flag.
- R7: Opcode 0x03 is followed by a 16-bit address (upper four bits zero). Bytes then stream from that address, which increments after each byte and rolls from 0xFFF to 0x000.
- R8: Opcode 0x02 needs WEL=1, else the whole access is ignored. Each data byte lands at the next offset in the low five address bits. The offset wraps within the page, so later bytes overwrite earlier ones.
- R9: A write cycle starts only when chip select rises on a byte boundary after at least one data byte. At any other point the access is dropped and WEL stays set.
- R10: Opcode 0x01 followed by one byte needs WEL=1 and the neighbour's status permission. The byte is handed out on `sr_we` at the end of the write cycle.
- R11: WIP stays 1 for WR_CYCLES clocks and then through the commit. Buffered bytes at locked addresses are not written. WIP and WEL fall in the same cycle.
- R12: While WIP=1, every opcode except 0x05 is ignored, and no output is driven for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |
| miso_oe | output | 1 | Output enable for `miso` |
| mem_raddr | output | ADDR_W | Array read address |
| mem_rdata | input | 8 | Array read data (combinational) |
| mem_we | output | 1 | Array byte write strobe |
| mem_waddr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |
| prot_wr_ok | input | 1 | Address on `mem_waddr` may be written |
| prot_sr_ok | input | 1 | Status byte may be changed |
| prot_sr_bits | input | 3 | Stored status bits {enable, lock1, lock0} |
| sr_we | output | 1 | Status byte write strobe |
| sr_wdata | output | 8 | Status byte to store |

## Verification
The bench targets the points where the access must be dropped: a write-enable followed by a ninth clock, a selection that ends four bits into a data byte, a write with no WEL, and a status write made while the neighbour forbids it. A design that gets these wrong would set WEL or start a timed cycle it must not. It also checks a 34-byte burst that wraps inside its page and a read that crosses 0xFFF. A wrong offset counter would overwrite the next page or read from the wrong place. Commands sent during WIP must not clear WEL and must not drive the output. Bytes aimed at a locked quarter of the array must remain unchanged.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_SFLAG = 8'h00;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;

    typedef enum logic [3:0] {
        ST_IDLE, ST_OPC, ST_ADDR, ST_RD, ST_RDSR,
        ST_WR, ST_SDATA, ST_SDONE, ST_WREN, ST_IGN
    } st_e;

    typedef enum logic { WK_ARRAY, WK_STATUS } wkind_e;

    typedef struct packed {
        logic cs_fall;
        logic cs_rise;
        logic sck_rise;
        logic sck_fall;
        logic si;
    } bus_ev_t;

    function automatic logic [7:0] status_byte(input logic [2:0] nv, input logic flag,
                                               input logic wel, input logic wip);
        return {nv[2], flag, 2'b11, nv[1:0], wel, wip};
    endfunction

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync
    import spi_mem_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    cs_n,
    input  logic    sck,
    input  logic    si,
    output bus_ev_t ev
);
    logic [STAGES:0]   cs_q;
    logic [STAGES:0]   sck_q;
    logic [STAGES-1:0] si_q;

    // chip select resets to "low": a select held low through reset shows no fall
    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q  <= '0;
            sck_q <= '0;
            si_q  <= '0;
        end else begin
            cs_q  <= {cs_q[STAGES-1:0], cs_n};
            sck_q <= {sck_q[STAGES-1:0], sck};
            si_q  <= {si_q[STAGES-2:0], si};
        end
    end

    always_comb begin
        ev.cs_fall  = cs_q[STAGES] & ~cs_q[STAGES-1];
        ev.cs_rise  = ~cs_q[STAGES] & cs_q[STAGES-1];
        ev.sck_rise = ~sck_q[STAGES] & sck_q[STAGES-1];
        ev.sck_fall = sck_q[STAGES] & ~sck_q[STAGES-1];
        ev.si       = si_q[STAGES-1];
    end
endmodule

// File: rtl/spi_mem_pagebuf.sv
module spi_mem_pagebuf #(
    parameter int PAGE_W = 5,
    localparam int PAGE_BYTES = 1 << PAGE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_idx,
    input  logic [7:0]        wr_data,
    input  logic [PAGE_W-1:0] rd_idx,
    output logic [7:0]        rd_data,
    output logic              rd_valid
);
    logic [7:0]            bytes_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld_q;

    always_ff @(posedge clk) begin
        if (wr_en) bytes_q[wr_idx] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clr)  vld_q <= '0;
        else if (wr_en)  vld_q[wr_idx] <= 1'b1;
    end

    assign rd_data  = bytes_q[rd_idx];
    assign rd_valid = vld_q[rd_idx];
endmodule

// File: rtl/spi_mem_wtimer.sv
module spi_mem_wtimer #(
    parameter int CYCLES = 20000,
    localparam int CW = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (start)      cnt <= CW'(CYCLES);
        else if (cnt != '0)  cnt <= cnt - CW'(1);
    end

    assign done = (cnt == CW'(1));
endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int PAGE_W    = 5,
    parameter int WR_CYCLES = 20000,
    parameter int SYNC_STG  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              mosi,
    output logic              miso,
    output logic              miso_oe,
    output logic [ADDR_W-1:0] mem_raddr,
    input  logic [7:0]        mem_rdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [7:0]        mem_wdata,
    input  logic              prot_wr_ok,
    input  logic              prot_sr_ok,
    input  logic [2:0]        prot_sr_bits,
    output logic              sr_we,
    output logic [7:0]        sr_wdata
);
    localparam int HI_W = ADDR_W - 8;
    localparam int PB_W = ADDR_W - PAGE_W;
    localparam logic [PAGE_W-1:0] LAST_IDX = '1;

    bus_ev_t ev;
    st_e     state;
    wkind_e  wkind;
    logic [2:0]        bitcnt;
    logic [6:0]        sh;
    logic [HI_W-1:0]   hi_q;
    logic              addr_hi, op_wr, got_byte;
    logic [ADDR_W-1:0] rd_addr;
    logic              load_pend, out_en, so_q;
    logic [7:0]        out_sh, sr_data;
    logic              wel, wip, flag, committing;
    logic [PB_W-1:0]   page_base;
    logic [PAGE_W-1:0] ptr, cidx;

    logic [7:0]        byte_in, status_now;
    logic [ADDR_W-1:0] full_addr;
    logic              byte_done, start_arr, start_sr, tmr_done;
    logic              pb_clr, pb_wr, pb_valid;
    logic [7:0]        pb_data;

    spi_mem_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(mosi), .ev(ev)
    );

    spi_mem_pagebuf #(.PAGE_W(PAGE_W)) u_pbuf (
        .clk(clk), .rst(rst), .clr(pb_clr), .wr_en(pb_wr), .wr_idx(ptr),
        .wr_data(byte_in), .rd_idx(cidx), .rd_data(pb_data), .rd_valid(pb_valid)
    );

    spi_mem_wtimer #(.CYCLES(WR_CYCLES)) u_tmr (
        .clk(clk), .rst(rst), .start(start_arr | start_sr), .done(tmr_done)
    );

    always_comb begin
        byte_in    = {sh, ev.si};
        full_addr  = {hi_q, byte_in};
        status_now = status_byte(prot_sr_bits, flag, wel, wip);
        byte_done  = ev.sck_rise && !ev.cs_rise && !ev.cs_fall
                     && state != ST_IDLE && bitcnt == 3'd7;
        start_arr  = ev.cs_rise && state == ST_WR && bitcnt == 3'd0 && got_byte;
        start_sr   = ev.cs_rise && state == ST_SDONE && bitcnt == 3'd0 && prot_sr_ok;
        pb_clr     = byte_done && state == ST_ADDR && addr_hi && op_wr;
        pb_wr      = byte_done && state == ST_WR;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;  wkind <= WK_ARRAY;  bitcnt <= '0;  sh <= '0;
            hi_q <= '0;  addr_hi <= 1'b0;  op_wr <= 1'b0;  got_byte <= 1'b0;
            rd_addr <= '0;  load_pend <= 1'b0;  out_en <= 1'b0;  so_q <= 1'b0;
            out_sh <= '0;  sr_data <= '0;  wel <= 1'b0;  wip <= 1'b0;
            flag <= 1'b0;  committing <= 1'b0;  page_base <= '0;  ptr <= '0;  cidx <= '0;
        end else begin
            if (ev.sck_fall) begin
                so_q   <= out_sh[7];
                out_sh <= {out_sh[6:0], 1'b0};
            end
            if (load_pend) begin
                out_sh    <= mem_rdata;
                rd_addr   <= rd_addr + ADDR_W'(1);
                load_pend <= 1'b0;
            end

            if (ev.cs_rise) begin
                if (state == ST_WREN && bitcnt == 3'd0) wel <= 1'b1;
                if (start_arr) begin wip <= 1'b1; wkind <= WK_ARRAY;  end
                if (start_sr)  begin wip <= 1'b1; wkind <= WK_STATUS; end
                state  <= ST_IDLE;
                out_en <= 1'b0;
            end else if (ev.cs_fall) begin
                state  <= ST_OPC;
                bitcnt <= '0;
            end else if (ev.sck_rise && state != ST_IDLE) begin
                bitcnt <= bitcnt + 3'd1;
                sh     <= byte_in[6:0];
                if (state == ST_WREN || state == ST_SDONE) state <= ST_IGN;
                if (byte_done) begin
                    unique case (state)
                        ST_OPC: begin
                            if (wip && byte_in != OP_RDSR) state <= ST_IGN;
                            else begin
                                case (byte_in)
                                    OP_WREN:  state <= ST_WREN;
                                    OP_WRDI:  begin wel <= 1'b0; flag <= 1'b0; state <= ST_IGN; end
                                    OP_SFLAG: begin flag <= 1'b1; state <= ST_IGN; end
                                    OP_RDSR:  begin out_sh <= status_now; out_en <= 1'b1; state <= ST_RDSR; end
                                    OP_WRSR:  state <= wel ? ST_SDATA : ST_IGN;
                                    OP_READ:  begin op_wr <= 1'b0; addr_hi <= 1'b0; state <= ST_ADDR; end
                                    OP_WRITE: begin
                                        op_wr <= 1'b1; addr_hi <= 1'b0;
                                        state <= wel ? ST_ADDR : ST_IGN;
                                    end
                                    default:  state <= ST_IGN;
                                endcase
                            end
                        end
                        ST_ADDR: begin
                            addr_hi <= 1'b1;
                            hi_q    <= byte_in[HI_W-1:0];
                            if (addr_hi && op_wr) begin
                                page_base <= full_addr[ADDR_W-1:PAGE_W];
                                ptr       <= full_addr[PAGE_W-1:0];
                                got_byte  <= 1'b0;
                                state     <= ST_WR;
                            end else if (addr_hi) begin
                                rd_addr   <= full_addr;
                                load_pend <= 1'b1;
                                out_en    <= 1'b1;
                                state     <= ST_RD;
                            end
                        end
                        ST_RD:    load_pend <= 1'b1;
                        ST_RDSR:  out_sh <= status_now;
                        ST_WR:    begin ptr <= ptr + PAGE_W'(1); got_byte <= 1'b1; end
                        ST_SDATA: begin sr_data <= byte_in; state <= ST_SDONE; end
                        default: ;
                    endcase
                end
            end

            if (tmr_done) begin
                committing <= 1'b1;
                cidx       <= '0;
            end else if (committing) begin
                if (wkind == WK_STATUS || cidx == LAST_IDX) begin
                    committing <= 1'b0;
                    wip        <= 1'b0;
                    wel        <= 1'b0;
                end else begin
                    cidx <= cidx + PAGE_W'(1);
                end
            end
        end
    end

    assign miso      = so_q;
    assign miso_oe   = out_en & ~cs_n;
    assign mem_raddr = rd_addr;
    assign mem_waddr = {page_base, cidx};
    assign mem_wdata = pb_data;
    assign mem_we    = committing && wkind == WK_ARRAY && pb_valid && prot_wr_ok;
    assign sr_we     = committing && wkind == WK_STATUS;
    assign sr_wdata  = sr_data;
endmodule

// File: rtl/spi_mem_chk.sv
module spi_mem_chk
    import spi_mem_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic wip,
    input logic wel,
    input logic mem_we,
    input logic sr_we,
    input logic cs_rise,
    input logic miso_oe,
    input st_e  st
);
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !miso_oe);

    p_ignored_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IGN) |-> !miso_oe);

    p_start_needs_wel_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(wip) |-> $past(wel));

    p_start_at_csrise_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(wip) |-> $past(cs_rise));

    p_sr_we_in_cycle_r10: assert property (@(posedge clk) disable iff (rst)
        sr_we |-> wip);

    p_mem_we_in_cycle_r11: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> wip);

    p_clear_together_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(wip) |-> !wel);
endmodule

bind spi_mem_ctrl spi_mem_chk u_chk (
    .clk(clk), .rst(rst), .wip(wip), .wel(wel), .mem_we(mem_we), .sr_we(sr_we),
    .cs_rise(ev.cs_rise), .miso_oe(miso_oe), .st(state)
);

// File: tb/tb_spi_mem_ctrl.sv
`timescale 1ns/1ps
module tb_spi_mem_ctrl;
    localparam int CLK_P = 10;
    localparam int HALF  = 8;
    localparam int WRC   = 2000;

    logic clk = 1'b0, rst = 1'b1, cs_n = 1'b0, sck = 1'b0, mosi = 1'b0;
    logic miso, miso_oe, mem_we, sr_we;
    logic [11:0] mem_raddr, mem_waddr;
    logic [7:0]  mem_rdata, mem_wdata, sr_wdata;
    logic prot_wr_ok, prot_sr_ok;
    logic wpen = 1'b0, wp_pin = 1'b1, mode3 = 1'b0, oe_seen;
    logic [1:0] bl = 2'b00;
    logic [7:0] arr [4096];
    logic [7:0] expm [4096];
    logic [7:0] wbuf [40];
    logic [7:0] rbuf [40];
    int n_chk = 0, n_err = 0;

    always #(CLK_P/2) clk = ~clk;

    function automatic logic locked(input logic [11:0] a, input logic [1:0] b);
        case (b)
            2'd1:    return a >= 12'hC00;
            2'd2:    return a >= 12'h800;
            2'd3:    return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    assign mem_rdata  = arr[mem_raddr];
    assign prot_wr_ok = !locked(mem_waddr, bl);
    assign prot_sr_ok = !(wpen && !wp_pin);
    always_ff @(posedge clk) begin
        if (mem_we) arr[mem_waddr] <= mem_wdata;
        if (sr_we) begin wpen <= sr_wdata[7]; bl <= sr_wdata[3:2]; end
    end

    spi_mem_ctrl #(.WR_CYCLES(WRC)) dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso),
        .miso_oe(miso_oe), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .prot_wr_ok(prot_wr_ok), .prot_sr_ok(prot_sr_ok), .prot_sr_bits({wpen, bl}),
        .sr_we(sr_we), .sr_wdata(sr_wdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, input int nb, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i >= 8 - nb; i--) begin
            if (mode3) sck = 1'b0;
            mosi = tx[i];
            clocks(HALF);
            rx[i] = miso;
            oe_seen = oe_seen | miso_oe;
            sck = 1'b1;
            clocks(HALF);
            if (!mode3) sck = 1'b0;
        end
    endtask

    task automatic sel();
        sck = mode3;
        clocks(4);
        cs_n = 1'b0;
        oe_seen = 1'b0;
        clocks(HALF);
    endtask

    task automatic desel();
        clocks(4);
        cs_n = 1'b1;
        clocks(HALF);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] d;
        sel(); xfer(op, 8, d); desel();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] d;
        sel(); xfer(8'h05, 8, d); xfer(8'h00, 8, s); desel();
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] d;
        sel(); xfer(8'h01, 8, d); xfer(v, 8, d); desel();
    endtask

    task automatic rd(input logic [11:0] a, input int n);
        logic [7:0] d;
        sel(); xfer(8'h03, 8, d); xfer({4'h0, a[11:8]}, 8, d); xfer(a[7:0], 8, d);
        for (int k = 0; k < n; k++) xfer(8'h00, 8, rbuf[k]);
        desel();
    endtask

    task automatic wr(input logic [11:0] a, input int n, input int extra_bits);
        logic [7:0] d;
        sel(); xfer(8'h02, 8, d); xfer({4'h0, a[11:8]}, 8, d); xfer(a[7:0], 8, d);
        for (int k = 0; k < n; k++) xfer(wbuf[k], 8, d);
        if (extra_bits > 0) xfer(8'hA5, extra_bits, d);
        desel();
    endtask

    task automatic model_write(input logic [11:0] a, input int n);
        logic [7:0] pb [32];
        logic [31:0] v;
        v = '0;
        for (int k = 0; k < n; k++) begin
            pb[(a[4:0] + k) % 32] = wbuf[k];
            v[(a[4:0] + k) % 32] = 1'b1;
        end
        for (int o = 0; o < 32; o++) begin
            logic [11:0] t;
            t = {a[11:5], 5'(o)};
            if (v[o] && !locked(t, bl)) expm[t] = pb[o];
        end
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int k = 0; k < 40; k++) begin
            rdsr(s);
            if (!s[0]) break;
        end
    endtask

    task automatic cmp_read(input string req, input logic [11:0] a, input int n);
        rd(a, n);
        for (int k = 0; k < n; k++) chk(req, rbuf[k], expm[12'(a + 12'(k))]);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) begin
            arr[i]  = 8'(i * 7 + 3);
            expm[i] = 8'(i * 7 + 3);
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        $display("FAIL R11 watchdog act=hung exp=finished");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0] s, d;
        logic [11:0] ra;
        int rn;
        void'($urandom(32'h5eed));
        clocks(6);
        rst = 1'b0;
        clocks(4);
        chk("R3 reset oe", miso_oe, 1'b0);

        // R2: select held low through reset, no falling edge seen
        oe_seen = 1'b0;
        xfer(8'h05, 8, d); xfer(8'h00, 8, d);
        chk("R2 no select fall", oe_seen, 1'b0);
        desel();
        chk("R3 deselected oe", miso_oe, 1'b0);

        rdsr(s);        chk("R4 reset status", s, 8'h30);
        cmd1(8'h06);    rdsr(s); chk("R5 wren", s, 8'h32);
        cmd1(8'h04);    rdsr(s); chk("R6 wrdi", s, 8'h30);
        cmd1(8'h00);    rdsr(s); chk("R6 set flag", s, 8'h70);
        cmd1(8'h04);    rdsr(s); chk("R6 clear flag", s, 8'h30);

        sel(); xfer(8'h06, 8, d); xfer(8'h00, 1, d); desel();
        rdsr(s); chk("R5 wren with extra clock", s, 8'h30);

        wbuf[0] = 8'hDE; wbuf[1] = 8'hAD;
        wr(12'h100, 2, 0);
        rdsr(s); chk("R8 write without wel status", s, 8'h30);
        cmp_read("R8 write without wel data", 12'h100, 2);

        // mode 0 write, then activity during the timed cycle
        for (int k = 0; k < 4; k++) wbuf[k] = 8'h11 * 8'(k + 1);
        cmd1(8'h06);
        wr(12'h010, 4, 0);
        rdsr(s); chk("R11 busy status", s, 8'h33);
        cmd1(8'h04);
        rd(12'h010, 2);
        chk("R12 read ignored while busy", oe_seen, 1'b0);
        rdsr(s); chk("R12 wrdi ignored while busy", s, 8'h33);
        wait_idle();
        rdsr(s); chk("R11 wip and wel cleared", s, 8'h30);
        model_write(12'h010, 4);
        cmp_read("R1 mode0 read", 12'h010, 4);
        mode3 = 1'b1;
        cmp_read("R1 mode3 read", 12'h00E, 6);
        mode3 = 1'b0;
        sck = 1'b0;

        // page wrap with overwrite
        for (int k = 0; k < 34; k++) wbuf[k] = 8'(8'h80 + k);
        cmd1(8'h06);
        wr(12'h03E, 34, 0);
        wait_idle();
        model_write(12'h03E, 34);
        cmp_read("R8 page wrap", 12'h020, 32);
        cmp_read("R8 next page untouched", 12'h040, 2);

        // dropped write
        wbuf[0] = 8'h5A; wbuf[1] = 8'hA5;
        cmd1(8'h06);
        wr(12'h200, 2, 4);
        rdsr(s); chk("R9 mid-byte select rise", s, 8'h32);
        cmp_read("R9 mid-byte data unchanged", 12'h200, 2);
        wr(12'h200, 0, 0);
        rdsr(s); chk("R9 no data byte", s, 8'h32);
        cmd1(8'h04);

        cmp_read("R7 rollover", 12'hFFE, 4);

        // status write and lock range
        cmd1(8'h06);
        wrsr(8'h04);
        rdsr(s); chk("R10 status cycle busy", s[0], 1'b1);
        wait_idle();
        rdsr(s); chk("R10 lock bits stored", s, 8'h34);
        wbuf[0] = 8'hC3; wbuf[1] = 8'h3C;
        cmd1(8'h06); wr(12'hC00, 2, 0); wait_idle(); model_write(12'hC00, 2);
        cmp_read("R11 locked bytes kept", 12'hC00, 2);
        cmd1(8'h06); wr(12'hBF0, 2, 0); wait_idle(); model_write(12'hBF0, 2);
        cmp_read("R11 unlocked bytes written", 12'hBF0, 2);

        // status permission from neighbour
        cmd1(8'h06); wrsr(8'h84); wait_idle();
        rdsr(s); chk("R4 enable bit shown", s, 8'hB4);
        wp_pin = 1'b0;
        cmd1(8'h06); wrsr(8'h00);
        rdsr(s); chk("R10 status write refused", s, 8'hB6);
        wp_pin = 1'b1;
        wrsr(8'h00); wait_idle();
        rdsr(s); chk("R10 status write allowed", s, 8'h30);
        wrsr(8'h0C);
        rdsr(s); chk("R10 status write without wel", s, 8'h30);

        // random page writes and reads
        for (int it = 0; it < 10; it++) begin
            ra = 12'($urandom);
            rn = 1 + int'($urandom % 12);
            for (int k = 0; k < rn; k++) wbuf[k] = 8'($urandom);
            mode3 = 1'($urandom);
            cmd1(8'h06);
            wr(ra, rn, 0);
            wait_idle();
            model_write(ra, rn);
            cmp_read("R7 random readback", {ra[11:5], 5'd0}, 12);
            mode3 = 1'b0;
            sck = 1'b0;
        end

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule